// File: doc/BRIEF.md
# I2C Bit-Rate Tick Generator

This block turns a fast system clock into the timing pulses an I2C master needs to pace its clock line. A 7-bit rate setting holds two fields: a linear factor M and an exponent N. The system clock is first divided by M+1. That result is divided again by 2^(N+1). The pulse this produces, the sample tick, runs at ten times the SCL bit rate. A phase sequencer then counts these ticks in groups of ten. The first five form the low half of an SCL period and the last five form the high half. The resulting SCL frequency is clk / (10 × (M+1) × 2^(N+1)).

The rate setting is loaded through a plain write strobe with an 8-bit data word. Every load restarts the whole divider chain and the phase sequencer from zero, so no period of mixed length appears around a change. A synchronous soft-reset input puts the setting back to its power-on value and restarts the chain. An asynchronous active-low reset does the same at power-up. The master controller reads the tick, phase and half-period outputs as plain level and pulse signals. There is no data stream and no handshake at this block's edge.

Top module: `i2c_baud_div`

## Requirements
- R1: After rst_n is released, baud_q reads 0x44, which is M=8 and N=4. The sample tick period is then 288 clock cycles.
- R2: A write with baud_we=1 loads baud_wdata[6:3] as M and baud_wdata[2:0] as N. Bit 7 of the written word is ignored, and baud_q[7] always reads 0.
- R3: sample_tick is a single-cycle pulse that repeats every D = (M+1)×2^(N+1) clock cycles.
- R4: A write restarts the divider chain. If the write takes effect at a clock edge, the first sample_tick after it is high in the cycle that ends D edges later, and phase_idx reads 0 right after that edge.
- R5: soft_rst=1 at an edge restores baud_q to 0x44 and restarts the chain and the phase sequencer. It takes priority over a write in the same cycle.
- R6: phase_idx advances by one on each sample_tick, from 0 up to 9 and then back to 0. It holds its value between ticks.
- R7: scl_high is 0 while phase_idx is 0 to 4 and 1 while phase_idx is 5 to 9.
- R8: bit_tick pulses together with the sample_tick that ends phase 9. This happens once every 10×D cycles.
- R9: The extreme settings work. Setting 0x00 gives D=2, and setting 0x7F gives D=4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous restore of the default rate and restart of the chain |
| baud_we | input | 1 | Write strobe for the rate setting |
| baud_wdata | input | 8 | Rate setting: M in bits 6:3, N in bits 2:0, bit 7 ignored |
| baud_q | output | 8 | Current rate setting, bit 7 always 0 |
| sample_tick | output | 1 | Pulse at ten times the SCL rate |
| phase_idx | output | 4 | Position of the current sample within the bit, 0 to 9 |
| scl_high | output | 1 | 1 during the high half of the SCL period |
| bit_tick | output | 1 | Pulse at the end of each full SCL period |

## Verification
The bench builds the block with its default parameters: ten ticks per bit, five of them low, and a power-on setting of 0x44. The M and N field widths come from the package. Programming the setting at run time gives access to the whole divisor range, from D=2 at 0x00 up to D=4096 at 0x7F. It also covers a setting with bit 7 set, a write that lands partway through a period, and a soft reset that coincides with a write. A behavioural model that counts cycles since the last restart predicts every output on every cycle.

// File: rtl/i2c_baud_pkg.sv
package i2c_baud_pkg;
  // Field widths of the rate setting
  localparam int BAUD_M_W = 4;
  localparam int BAUD_N_W = 3;
  localparam int BAUD_W   = 8;
  localparam int CFG_W    = BAUD_M_W + BAUD_N_W;
  // Exponent counter spans up to 2^(2^N_W) cycles
  localparam int POW_CW   = 1 << BAUD_N_W;

  typedef struct packed {
    logic [BAUD_M_W-1:0] m;
    logic [BAUD_N_W-1:0] n;
  } baud_cfg_t;

  function automatic baud_cfg_t cfg_from_word(logic [BAUD_W-1:0] w);
    baud_cfg_t c;
    c.m = w[BAUD_N_W +: BAUD_M_W];
    c.n = w[BAUD_N_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/i2c_baud_reg.sv
module i2c_baud_reg
  import i2c_baud_pkg::*;
#(
  parameter logic [BAUD_W-1:0] RESET_VAL = 8'h44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              we,
  input  logic [BAUD_W-1:0] wdata,
  output baud_cfg_t         cfg,
  output logic [BAUD_W-1:0] word_q,
  output logic              reload
);
  localparam baud_cfg_t CFG_RST = cfg_from_word(RESET_VAL);

  baud_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= CFG_RST;
    else if (soft_rst) cfg_q <= CFG_RST;
    else if (we)       cfg_q <= cfg_from_word(wdata);
  end

  assign cfg    = cfg_q;
  assign word_q = {{(BAUD_W-CFG_W){1'b0}}, cfg_q};
  assign reload = soft_rst | we;
endmodule

// File: rtl/i2c_lin_stage.sv
module i2c_lin_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] cnt_q;

  assign tick = (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2c_pow2_stage.sv
module i2c_pow2_stage #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CW = 1 << SEL_W;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] term;

  // Terminal count 2^(sel+1)-1: bits 0..sel are set
  for (genvar k = 0; k < CW; k++) begin : g_term
    assign term[k] = (SEL_W'(k) <= sel);
  end

  assign tick = step && (cnt_q == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else if (step) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2c_phase_seq.sv
module i2c_phase_seq #(
  parameter int TICKS = 10,
  parameter int LOW   = 5,
  localparam int PW   = $clog2(TICKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [PW-1:0] phase,
  output logic          high,
  output logic          wrap
);
  localparam logic [PW-1:0] LAST = PW'(TICKS - 1);
  localparam logic [PW-1:0] HIGH_AT = PW'(LOW);

  logic [PW-1:0] ph_q;

  assign wrap  = step && (ph_q == LAST);
  assign phase = ph_q;
  assign high  = (ph_q >= HIGH_AT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ph_q <= '0;
    else if (clr)  ph_q <= '0;
    else if (wrap) ph_q <= '0;
    else if (step) ph_q <= ph_q + 1'b1;
  end
endmodule

// File: rtl/i2c_baud_div.sv
module i2c_baud_div
  import i2c_baud_pkg::*;
#(
  parameter logic [7:0] RESET_BAUD = 8'h44,
  parameter int TICKS_PER_BIT      = 10,
  parameter int LOW_TICKS          = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       baud_we,
  input  logic [7:0] baud_wdata,
  output logic [7:0] baud_q,
  output logic       sample_tick,
  output logic [3:0] phase_idx,
  output logic       scl_high,
  output logic       bit_tick
);
  baud_cfg_t cfg;
  logic      reload;
  logic      lin_tick;

  i2c_baud_reg #(.RESET_VAL(RESET_BAUD)) u_reg (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .we(baud_we), .wdata(baud_wdata),
    .cfg(cfg), .word_q(baud_q), .reload(reload)
  );

  i2c_lin_stage #(.W(BAUD_M_W)) u_lin (
    .clk(clk), .rst_n(rst_n), .clr(reload),
    .limit(cfg.m), .tick(lin_tick)
  );

  i2c_pow2_stage #(.SEL_W(BAUD_N_W)) u_pow (
    .clk(clk), .rst_n(rst_n), .clr(reload),
    .step(lin_tick), .sel(cfg.n), .tick(sample_tick)
  );

  i2c_phase_seq #(.TICKS(TICKS_PER_BIT), .LOW(LOW_TICKS)) u_phase (
    .clk(clk), .rst_n(rst_n), .clr(reload), .step(sample_tick),
    .phase(phase_idx), .high(scl_high), .wrap(bit_tick)
  );
endmodule

// File: rtl/i2c_baud_div_chk.sv
module i2c_baud_div_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       baud_we,
  input logic [7:0] baud_q,
  input logic       sample_tick,
  input logic [3:0] phase_idx,
  input logic       scl_high,
  input logic       bit_tick
);
  logic [12:0] gap_q;
  int          exp_gap;

  always_comb exp_gap = ((int'(baud_q[6:3]) + 1) << (int'(baud_q[2:0]) + 1)) - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= '0;
    else if (soft_rst || baud_we || sample_tick) gap_q <= '0;
    else gap_q <= gap_q + 1'b1;
  end

  assert_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |-> (int'(gap_q) == exp_gap));
  assert_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> !sample_tick);
  assert_bit7_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    baud_q[7] == 1'b0);
  assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_we && !soft_rst) |=> (phase_idx == 4'd0 && !scl_high));
  assert_soft_default_R5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (baud_q == 8'h44 && phase_idx == 4'd0));
  assert_phase_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    phase_idx <= 4'd9);
  assert_phase_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_tick && !baud_we && !soft_rst) |=> $stable(phase_idx));
  assert_scl_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_high) |-> (phase_idx == 4'd5 && $past(sample_tick)));
  assert_bit_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> (phase_idx == 4'd0 && !scl_high));
endmodule

bind i2c_baud_div i2c_baud_div_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .baud_we(baud_we),
  .baud_q(baud_q), .sample_tick(sample_tick), .phase_idx(phase_idx),
  .scl_high(scl_high), .bit_tick(bit_tick)
);

// File: tb/test_i2c_baud_div.sv
module test_i2c_baud_div;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       baud_we = 1'b0;
  logic [7:0] baud_wdata = 8'h00;
  logic [7:0] baud_q;
  logic       sample_tick;
  logic [3:0] phase_idx;
  logic       scl_high;
  logic       bit_tick;

  int checks = 0;
  int failures = 0;
  bit cmp_en = 1'b0;
  int tick_cnt = 0;
  int bit_cnt = 0;

  // Reference model state
  int mdl_baud = 'h44;
  int mdl_cnt = 0;
  int mdl_phase = 0;

  i2c_baud_div i_i2c_baud_div (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .baud_we(baud_we),
    .baud_wdata(baud_wdata), .baud_q(baud_q), .sample_tick(sample_tick),
    .phase_idx(phase_idx), .scl_high(scl_high), .bit_tick(bit_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int divisor(int b);
    return (((b >> 3) & 15) + 1) * (2 << (b & 7));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdl_baud = 'h44; mdl_cnt = 0; mdl_phase = 0;
    end else if (soft_rst) begin
      mdl_baud = 'h44; mdl_cnt = 0; mdl_phase = 0;
    end else if (baud_we) begin
      mdl_baud = baud_wdata & 'h7F; mdl_cnt = 0; mdl_phase = 0;
    end else if (mdl_cnt == divisor(mdl_baud) - 1) begin
      mdl_cnt = 0;
      mdl_phase = (mdl_phase == 9) ? 0 : mdl_phase + 1;
    end else begin
      mdl_cnt++;
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      bit et;
      et = (mdl_cnt == divisor(mdl_baud) - 1);
      chk(baud_q == 8'(mdl_baud), "R2 baud_q", baud_q, mdl_baud);
      chk(sample_tick == et, "R3 sample_tick", sample_tick, et);
      chk(phase_idx == 4'(mdl_phase), "R6 phase_idx", phase_idx, mdl_phase);
      chk(scl_high == (mdl_phase >= 5), "R7 scl_high", scl_high, mdl_phase >= 5);
      chk(bit_tick == (et && mdl_phase == 9), "R8 bit_tick", bit_tick, et && mdl_phase == 9);
      if (sample_tick) tick_cnt++;
      if (bit_tick) bit_cnt++;
    end
  end

  task automatic write_baud(logic [7:0] v);
    @(negedge clk);
    baud_we = 1'b1; baud_wdata = v;
    @(negedge clk);
    baud_we = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    @(negedge clk);
    // R1: power-on setting
    chk(baud_q == 8'h44, "R1 reset baud", baud_q, 'h44);
    chk(phase_idx == 0, "R1 reset phase", phase_idx, 0);
    // R8: one full bit at the default rate (10 x 288 cycles)
    bit_cnt = 0;
    idle(2900);
    chk(bit_cnt == 1, "R8 bits at default rate", bit_cnt, 1);

    // R9: smallest divisor
    write_baud(8'h00);
    tick_cnt = 0;
    idle(100);
    chk(tick_cnt == 50, "R9 ticks at D=2", tick_cnt, 50);

    // R2: bit 7 ignored
    write_baud(8'h80);
    chk(baud_q == 8'h00, "R2 bit7 ignored", baud_q, 0);
    idle(40);

    // R3: M=1, N=3 gives D=32
    write_baud(8'h0B);
    tick_cnt = 0;
    idle(640);
    chk(tick_cnt == 20, "R3 ticks at D=32", tick_cnt, 20);

    // R4: write lands partway through a period
    write_baud(8'h13);
    idle(37);
    write_baud(8'h13);
    idle(300);

    // R5: soft reset wins over a simultaneous write
    @(negedge clk);
    soft_rst = 1'b1; baud_we = 1'b1; baud_wdata = 8'h05;
    @(negedge clk);
    soft_rst = 1'b0; baud_we = 1'b0;
    chk(baud_q == 8'h44, "R5 soft reset priority", baud_q, 'h44);
    chk(phase_idx == 0, "R5 phase restart", phase_idx, 0);
    idle(600);

    // R9: largest divisor 4096
    write_baud(8'h7F);
    tick_cnt = 0;
    idle(8200);
    chk(tick_cnt == 2, "R9 ticks at D=4096", tick_cnt, 2);

    // Back-to-back rate changes
    write_baud(8'h08);
    write_baud(8'h01);
    idle(200);

    cmp_en = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule